// File: doc/BRIEF.md
# Eager Context Snapshot Wrapper

This block sits between a preemptible processing core and a register-mapped task interface. The core marks each cycle in which it is in a resumable state. On each such cycle the wrapper copies the core's state code and its context vector into a small buffer of 32-bit words. Because the buffer always holds the latest resumable snapshot, a swap-out request from software is honoured at once. The wrapper raises a processor interrupt without waiting for the core. Software then reads the buffer and may reclaim the core's area.

To resume a task, software first writes the saved words back into the buffer. It then issues a swap-in command. The wrapper holds the core, presents the stored state and context on a one-cycle load strobe, and then releases the hold so that the core continues from the restored point. The context must fit in the buffer: word 0 carries the state code, and the following words carry the context. No acknowledge from the core and no completion handshake are used.

Top module: `ctx_snapshot_wrapper`

## Requirements
- R1: After reset, `irq`, `core_hold` and `core_load` are 0 and every buffer word reads 0.
- R2: When `core_snap_vld` is 1 and no swap-in is in progress, the next cycle word 0 holds the state code zero-extended to 32 bits. Word 1 holds context bits 31:0, and word 2 holds context bits 47:32 with its upper 16 bits zero (defaults STATE_W=4, CTX_W=48).
- R3: A snapshot leaves buffer words above the context region (word 3 by default) unchanged.
- R4: A software write of `sw_wdata` to word `sw_idx` takes effect at the next edge, and `sw_rdata` shows word `sw_idx` in the same cycle. A write overrides a snapshot on the same word in the same cycle, while the snapshot still updates the other words.
- R5: A `cmd_swap_out` pulse sets `irq` in the next cycle, whatever the core is doing.
- R6: `irq` stays at 1 until a `cmd_irq_ack` pulse, which clears it in the next cycle. When a request and an acknowledge arrive in the same cycle, `irq` is 1.
- R7: One cycle after an accepted `cmd_swap_in`, `core_hold` is 1 and `core_load` is 0. In the cycle after that, `core_load` and `core_hold` are both 1, and the load outputs carry word 0 bits STATE_W-1:0 and the context rebuilt from words 1 and 2. In the cycle after that, both are 0.
- R8: While `core_hold` is 1, `core_snap_vld` does not change the buffer.
- R9: A `cmd_swap_in` that arrives while a swap-in is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_snap_vld | input | 1 | Core is in a resumable state this cycle |
| core_state_in | input | STATE_W | Core state code to snapshot |
| core_ctx_in | input | CTX_W | Core context to snapshot |
| core_hold | output | 1 | Holds the core during a swap-in |
| core_load | output | 1 | One-cycle strobe: core loads the restore data |
| core_state_out | output | STATE_W | State code to restore |
| core_ctx_out | output | CTX_W | Context to restore |
| sw_idx | input | IDX_W | Buffer word selected for read and write |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Selected buffer word |
| cmd_swap_out | input | 1 | Swap-out request pulse |
| cmd_swap_in | input | 1 | Swap-in command pulse |
| cmd_irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Processor interrupt |

## Verification
Each registered result has a fixed latency. Buffer contents, `irq` and the entry into hold are due one edge after the stimulus, the load strobe two edges after an accepted swap-in, and the release three edges after it. Read data is combinational and is due in the same cycle as the index. The bench drives stimulus on the falling edge, lets the stated number of rising edges pass, and samples on the following falling edge. It reads buffer words back through `sw_idx` a little after setting the index. It also keeps snapshot and repeated swap-in inputs active across the exact cycles of the hold window, so that a one-cycle error in the blocking window shows up as a changed word.

// File: rtl/ctxw_pkg.sv
package ctxw_pkg;
  typedef enum logic [1:0] {
    SWC_IDLE = 2'd0,
    SWC_ARM  = 2'd1,
    SWC_LOAD = 2'd2
  } swc_state_e;

  localparam int unsigned WORD_W = 32;
endpackage

// File: rtl/ctxw_buffer.sv
module ctxw_buffer #(
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned STATE_W = 4,
  parameter int unsigned CTX_W   = 48,
  localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               snap_en,
  input  logic [STATE_W-1:0] snap_state,
  input  logic [CTX_W-1:0]   snap_ctx,
  input  logic               sw_wr_en,
  input  logic [IDX_W-1:0]   sw_idx,
  input  logic [31:0]        sw_wdata,
  output logic [31:0]        sw_rdata,
  output logic [STATE_W-1:0] rd_state,
  output logic [CTX_W-1:0]   rd_ctx
);
  localparam int unsigned CTX_WORDS = (CTX_W + 31) / 32;
  localparam int unsigned CTX_PAD   = CTX_WORDS * 32;

  logic [31:0] mem [DEPTH];

  // Word k of a snapshot: 0 is the state code, 1.. carry the context LSB first
  function automatic logic [31:0] snap_word(input int unsigned k,
                                            input logic [STATE_W-1:0] st,
                                            input logic [CTX_W-1:0] cx);
    logic [CTX_PAD-1:0] pad;
    pad = '0;
    pad[CTX_W-1:0] = cx;
    if (k == 0) return 32'(st);
    return pad[(k-1)*32 +: 32];
  endfunction

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic sw_hit;
    assign sw_hit = sw_wr_en && (32'(sw_idx) == w);
    if (w <= CTX_WORDS) begin : g_ctx
      always_ff @(posedge clk) begin
        if (!rst_n)       mem[w] <= '0;
        else if (sw_hit)  mem[w] <= sw_wdata;
        else if (snap_en) mem[w] <= snap_word(w, snap_state, snap_ctx);
      end
    end else begin : g_scratch
      always_ff @(posedge clk) begin
        if (!rst_n)      mem[w] <= '0;
        else if (sw_hit) mem[w] <= sw_wdata;
      end
    end
  end

  if (DEPTH == (1 << IDX_W)) begin : g_rd_full
    assign sw_rdata = mem[sw_idx];
  end else begin : g_rd_guard
    always_comb begin
      sw_rdata = '0;
      for (int i = 0; i < DEPTH; i++)
        if (32'(sw_idx) == i) sw_rdata = mem[i];
    end
  end

  always_comb begin
    logic [CTX_PAD-1:0] pad;
    for (int k = 0; k < CTX_WORDS; k++) pad[k*32 +: 32] = mem[k+1];
    rd_ctx   = pad[CTX_W-1:0];
    rd_state = mem[0][STATE_W-1:0];
  end

  AST_SNAP_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_en && !sw_wr_en) |=> (rd_state == $past(snap_state))) else $error("snap state"); // R2
  AST_SNAP_CTX: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_en && !sw_wr_en) |=> (rd_ctx == $past(snap_ctx))) else $error("snap ctx"); // R2
  AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!snap_en && !sw_wr_en) |=> ($stable(rd_ctx) && $stable(rd_state))) else $error("buffer drift"); // R8
endmodule

// File: rtl/ctxw_swap_ctrl.sv
module ctxw_swap_ctrl
  import ctxw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_swap_in,
  output logic core_hold,
  output logic core_load,
  output logic snap_block
);
  swc_state_e st_q, st_d;
  logic swap_in_go;

  assign swap_in_go = cmd_swap_in && (st_q == SWC_IDLE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SWC_IDLE: if (swap_in_go) st_d = SWC_ARM;
      SWC_ARM:  st_d = SWC_LOAD;
      SWC_LOAD: st_d = SWC_IDLE;
      default:  st_d = SWC_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= SWC_IDLE;
    else        st_q <= st_d;
  end

  assign core_hold  = (st_q != SWC_IDLE);
  assign core_load  = (st_q == SWC_LOAD);
  assign snap_block = core_hold;

  AST_ARM_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    swap_in_go |=> (core_hold && !core_load)) else $error("arm"); // R7
  AST_LOAD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (core_hold && !core_load) |=> core_load) else $error("load"); // R7
  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    core_load |=> (!core_load && !core_hold)) else $error("release"); // R7
  AST_LOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    core_load |-> core_hold) else $error("load without hold"); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (core_hold && cmd_swap_in && !core_load) |=> core_load) else $error("restart"); // R9
endmodule

// File: rtl/ctxw_irq_ctrl.sv
module ctxw_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_swap_out,
  input  logic cmd_irq_ack,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)            irq <= 1'b0;
    else if (cmd_swap_out) irq <= 1'b1;
    else if (cmd_irq_ack)  irq <= 1'b0;
  end

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_swap_out |=> irq) else $error("irq set"); // R5
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !cmd_irq_ack) |=> irq) else $error("irq dropped"); // R6
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_irq_ack && !cmd_swap_out) |=> !irq) else $error("irq clear"); // R6
endmodule

// File: rtl/ctx_snapshot_wrapper.sv
module ctx_snapshot_wrapper #(
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned STATE_W = 4,
  parameter int unsigned CTX_W   = 48,
  localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               core_snap_vld,
  input  logic [STATE_W-1:0] core_state_in,
  input  logic [CTX_W-1:0]   core_ctx_in,
  output logic               core_hold,
  output logic               core_load,
  output logic [STATE_W-1:0] core_state_out,
  output logic [CTX_W-1:0]   core_ctx_out,
  input  logic [IDX_W-1:0]   sw_idx,
  input  logic               sw_wr_en,
  input  logic [31:0]        sw_wdata,
  output logic [31:0]        sw_rdata,
  input  logic               cmd_swap_out,
  input  logic               cmd_swap_in,
  input  logic               cmd_irq_ack,
  output logic               irq
);
  logic snap_block;
  logic snap_en;

  assign snap_en = core_snap_vld && !snap_block;

  ctxw_swap_ctrl i_swap (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_swap_in(cmd_swap_in),
    .core_hold  (core_hold),
    .core_load  (core_load),
    .snap_block (snap_block)
  );

  ctxw_buffer #(.DEPTH(DEPTH), .STATE_W(STATE_W), .CTX_W(CTX_W)) i_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .snap_en   (snap_en),
    .snap_state(core_state_in),
    .snap_ctx  (core_ctx_in),
    .sw_wr_en  (sw_wr_en),
    .sw_idx    (sw_idx),
    .sw_wdata  (sw_wdata),
    .sw_rdata  (sw_rdata),
    .rd_state  (core_state_out),
    .rd_ctx    (core_ctx_out)
  );

  ctxw_irq_ctrl i_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_swap_out(cmd_swap_out),
    .cmd_irq_ack (cmd_irq_ack),
    .irq         (irq)
  );

  AST_SNAP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (core_hold && !sw_wr_en) |=> ($stable(core_state_out) && $stable(core_ctx_out))) else $error("snapshot during swap-in"); // R8
endmodule

// File: tb/test_ctx_snapshot_wrapper.sv
module test_ctx_snapshot_wrapper;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4, STATE_W = 4, CTX_W = 48, IDX_W = 2;
  localparam int NVEC = 6;
  // {state, context} snapshot vectors
  localparam logic [51:0] VEC [NVEC] = '{
    {4'h1, 48'h0000_0000_0001},
    {4'hF, 48'hFFFF_FFFF_FFFF},
    {4'hA, 48'h1234_89AB_CDEF},
    {4'h0, 48'h8000_0000_0000},
    {4'h5, 48'h0000_FFFF_0000},
    {4'h9, 48'hCAFE_0000_BEEF}
  };

  logic clk = 0, rst_n = 0;
  logic core_snap_vld = 0, sw_wr_en = 0, cmd_swap_out = 0, cmd_swap_in = 0, cmd_irq_ack = 0;
  logic [STATE_W-1:0] core_state_in = '0;
  logic [CTX_W-1:0] core_ctx_in = '0;
  logic [IDX_W-1:0] sw_idx = '0;
  logic [31:0] sw_wdata = '0;
  logic core_hold, core_load, irq;
  logic [STATE_W-1:0] core_state_out;
  logic [CTX_W-1:0] core_ctx_out;
  logic [31:0] sw_rdata;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctx_snapshot_wrapper #(.DEPTH(DEPTH), .STATE_W(STATE_W), .CTX_W(CTX_W)) i_ctx_snapshot_wrapper (
    .clk(clk), .rst_n(rst_n), .core_snap_vld(core_snap_vld), .core_state_in(core_state_in),
    .core_ctx_in(core_ctx_in), .core_hold(core_hold), .core_load(core_load),
    .core_state_out(core_state_out), .core_ctx_out(core_ctx_out), .sw_idx(sw_idx),
    .sw_wr_en(sw_wr_en), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .cmd_swap_out(cmd_swap_out),
    .cmd_swap_in(cmd_swap_in), .cmd_irq_ack(cmd_irq_ack), .irq(irq));

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    sw_idx = IDX_W'(idx);
    #1;
    v = sw_rdata;
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    sw_idx = IDX_W'(idx); sw_wdata = d; sw_wr_en = 1;
    tick();
    sw_wr_en = 0;
  endtask

  task automatic chk_word(input int idx, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd(idx, v);
    chk(v === exp, req, 64'(v), 64'(exp));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] w3;
    logic [63:0] st_save, cx_save;
    @(negedge clk);
    tick(); tick();
    // R1: reset state
    chk({irq, core_hold, core_load} === 3'b000, "R1", 64'({irq, core_hold, core_load}), 64'd0);
    for (int i = 0; i < DEPTH; i++) chk_word(i, 32'h0, "R1");
    rst_n = 1;
    tick();

    // R3 preparation: scratch word
    wr(3, 32'h5A5A_0F0F);

    // R2/R3: table of snapshots
    for (int v = 0; v < NVEC; v++) begin
      logic [STATE_W-1:0] es;
      logic [CTX_W-1:0] ec;
      {es, ec} = VEC[v];
      core_state_in = es; core_ctx_in = ec; core_snap_vld = 1;
      tick();
      core_snap_vld = 0;
      chk_word(0, {28'h0, es}, "R2");
      chk_word(1, ec[31:0], "R2");
      chk_word(2, 32'((ec >> 32) & 48'hFFFF), "R2");
      chk_word(3, 32'h5A5A_0F0F, "R3");
    end

    // R4: write overrides snapshot on same word, others still snapshot
    core_state_in = 4'h3; core_ctx_in = 48'hAAAA_1111_2222; core_snap_vld = 1;
    sw_idx = 1; sw_wdata = 32'hDEAD_BEEF; sw_wr_en = 1;
    tick();
    core_snap_vld = 0; sw_wr_en = 0;
    chk_word(1, 32'hDEAD_BEEF, "R4");
    chk_word(0, 32'h3, "R4");
    chk_word(2, 32'h0000_AAAA, "R4");

    // R5/R6: interrupt
    cmd_swap_out = 1; tick(); cmd_swap_out = 0;
    chk(irq === 1'b1, "R5", 64'(irq), 64'd1);
    tick(); tick();
    chk(irq === 1'b1, "R6", 64'(irq), 64'd1);
    cmd_swap_out = 1; cmd_irq_ack = 1; tick(); cmd_swap_out = 0;
    chk(irq === 1'b1, "R6", 64'(irq), 64'd1);
    tick(); cmd_irq_ack = 0;
    chk(irq === 1'b0, "R6", 64'(irq), 64'd0);

    // R7/R8/R9: preload and swap in
    wr(0, 32'h0000_000C);
    wr(1, 32'h7654_3210);
    wr(2, 32'h0000_FEDC);
    st_save = 64'hC; cx_save = 64'h0000_FEDC_7654_3210;
    cmd_swap_in = 1; tick();
    chk(core_hold === 1'b1 && core_load === 1'b0, "R7", 64'({core_hold, core_load}), 64'b10);
    core_snap_vld = 1; core_state_in = 4'h1; core_ctx_in = 48'h1111_1111_1111;
    tick();
    chk(core_hold === 1'b1 && core_load === 1'b1, "R7", 64'({core_hold, core_load}), 64'b11);
    chk(64'(core_state_out) === st_save, "R7", 64'(core_state_out), st_save);
    chk(64'(core_ctx_out) === cx_save, "R7", 64'(core_ctx_out), cx_save);
    tick();
    core_snap_vld = 0; cmd_swap_in = 0;
    chk(core_hold === 1'b0 && core_load === 1'b0, "R7", 64'({core_hold, core_load}), 64'b00);
    chk_word(0, 32'h0000_000C, "R8");
    chk_word(1, 32'h7654_3210, "R8");
    chk_word(2, 32'h0000_FEDC, "R8");
    tick();
    chk(core_hold === 1'b0, "R9", 64'(core_hold), 64'd0);
    rd(3, w3);
    chk(w3 === 32'h5A5A_0F0F, "R3", 64'(w3), 64'h5A5A_0F0F);

    // R2 again after release: snapshots resume
    core_state_in = 4'h7; core_ctx_in = 48'h0102_0304_0506; core_snap_vld = 1;
    tick(); core_snap_vld = 0;
    chk_word(0, 32'h7, "R2");
    chk_word(1, 32'h0304_0506, "R2");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule